// File: doc/BRIEF.md
# Capture-and-Storage Dispatch Scheduler

This block is the central controller of a multi-camera capture path. On a programmable period it pulses a start strobe to every image capture unit, and it collects completion reports from those units. Each report names a buffer in external memory by address and length. Completion reports also come from the processing pipeline and from the co-processor link, which delivers navigation records. The scheduler tracks buffers only by address. It never touches the pixel data.

Every accepted report becomes an item in one or two of three work queues: buffers waiting for the processing element, buffers waiting for the drive writer, and buffers waiting for the co-processor link. Each queue feeds its consumer through a valid/ready command channel. A consumer moves data only when it receives a command. Raw images go to processing. A processed result goes both to the drive and to the co-processor. Navigation records go to the drive only. A report whose destination queue is full is held off with ready low and is never dropped.

Top module: `dispatch_sched`

## Requirements
- R1: With `period_i` = P ≥ 1, `cap_start_o` is high in the cycle after rising edge n exactly when n is a multiple of P. Edges are counted from 1, starting at the first edge after reset is released. The strobe is therefore one cycle wide when P > 1. With P = 0 it never rises.
- R2: Capture reports come out on the processing command channel in the order they were accepted, with address and length unchanged.
- R3: A processing-result report enters both the drive queue and the co-processor queue. On the drive channel it carries tag 2'd1.
- R4: A navigation report enters the drive queue only, with tag 2'd2. It never appears on the co-processor channel.
- R5: At most one report is accepted per cycle, and a ready is only given to a requester whose valid is high. Among the requesters whose destination queues have space, capture unit 0 wins first, then higher capture indices, then the processing result, then navigation.
- R6: Each queue holds Q_DEPTH entries, and this count includes the entry currently presented on its channel. While a queue is full, every report that targets it sees ready low and stays pending. It is accepted once an entry leaves.
- R7: A command valid, once high, stays high with stable payload until its ready is seen. A report accepted into an empty queue shows up as a command valid after the edge that follows the accepting edge.
- R8: While reset is held and right after it, all command valids and the start strobe are low.
- R9: A processing-result report is held off whenever either the drive queue or the co-processor queue is full, even if the other queue has space.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| period_i | input | PERIOD_W | Capture period in cycles, 0 disables |
| cap_start_o | output | 1 | Start-acquisition strobe to all capture units |
| cap_rpt_valid_i | input | N_CAP | Capture completion report valid, one per unit |
| cap_rpt_addr_i | input | N_CAP*ADDR_W | Buffer addresses, unit i in slice i |
| cap_rpt_len_i | input | N_CAP*LEN_W | Buffer lengths, unit i in slice i |
| cap_rpt_ready_o | output | N_CAP | Report accepted, one per unit |
| pdone_valid_i | input | 1 | Processing result report valid |
| pdone_addr_i | input | ADDR_W | Result buffer address |
| pdone_len_i | input | LEN_W | Result buffer length |
| pdone_ready_o | output | 1 | Processing result accepted |
| nav_valid_i | input | 1 | Navigation record report valid |
| nav_addr_i | input | ADDR_W | Navigation buffer address |
| nav_len_i | input | LEN_W | Navigation buffer length |
| nav_ready_o | output | 1 | Navigation report accepted |
| proc_cmd_valid_o | output | 1 | Command to processing element valid |
| proc_cmd_addr_o | output | ADDR_W | Buffer to process |
| proc_cmd_len_o | output | LEN_W | Length of buffer to process |
| proc_cmd_ready_i | input | 1 | Processing element takes command |
| drv_cmd_valid_o | output | 1 | Command to drive writer valid |
| drv_cmd_addr_o | output | ADDR_W | Buffer to store |
| drv_cmd_len_o | output | LEN_W | Length to store |
| drv_cmd_tag_o | output | 2 | Buffer kind: 1 processed image, 2 navigation |
| drv_cmd_ready_i | input | 1 | Drive writer takes command |
| cop_cmd_valid_o | output | 1 | Command to co-processor link valid |
| cop_cmd_addr_o | output | ADDR_W | Buffer to transfer |
| cop_cmd_len_o | output | LEN_W | Length to transfer |
| cop_cmd_ready_i | input | 1 | Co-processor link takes command |

## Verification
The bound checker watches the handshake rules on every cycle. It checks that at most one report is accepted and never without a valid, that a lower capture index always blocks the next one, and that a full queue, as counted from the channel traffic, admits nothing. It also checks that an unaccepted command holds its payload, that drive tags are only 1 or 2, and that the start strobe does not repeat on back-to-back cycles. Only the bench scenarios show the things a per-cycle rule cannot see. These are the exact strobe spacing for each period, the FIFO order and payload values across a full queue, the one-cycle path from report to command, the routing of a result to two queues at once, and the release of a stalled report once space frees up.

// File: rtl/dsch_pkg.sv
package dsch_pkg;
  // Buffer kind carried on the drive command channel
  typedef enum logic [1:0] {
    TAG_RAW  = 2'd0,
    TAG_PROC = 2'd1,
    TAG_NAV  = 2'd2
  } buf_tag_e;
endpackage

// File: rtl/dsch_timer.sv
module dsch_timer #(
  parameter int PERIOD_W = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [PERIOD_W-1:0] period_i,
  output logic                start_o
);
  logic [PERIOD_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      start_o <= 1'b0;
    end else if (period_i == '0) begin
      cnt     <= '0;
      start_o <= 1'b0;
    end else if ((cnt + 1'b1) >= period_i) begin
      cnt     <= '0;
      start_o <= 1'b1;
    end else begin
      cnt     <= cnt + 1'b1;
      start_o <= 1'b0;
    end
  end
endmodule

// File: rtl/dsch_fifo.sv
module dsch_fifo #(
  parameter int WIDTH = 56,
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  output logic             full_o,
  output logic             out_valid,
  output logic [WIDTH-1:0] out_data,
  input  logic             out_ready
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr;
  logic [CW-1:0]    count;
  logic [CW-1:0]    occ;
  logic             load;

  assign load   = (!out_valid || out_ready) && (count != '0);
  assign occ    = count + CW'(out_valid);
  assign full_o = (occ >= CW'(DEPTH));

  // storage without reset so it maps onto block RAM
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_ptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (load) out_data <= mem[rd_ptr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr    <= '0;
      rd_ptr    <= '0;
      count     <= '0;
      out_valid <= 1'b0;
    end else begin
      if (wr_en) wr_ptr <= wr_ptr + 1'b1;
      if (load)  rd_ptr <= rd_ptr + 1'b1;
      count <= count + CW'(wr_en) - CW'(load);
      if (load)           out_valid <= 1'b1;
      else if (out_ready) out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/dsch_arb.sv
module dsch_arb #(
  parameter int N = 4
) (
  input  logic [N-1:0] req,
  input  logic [N-1:0] elig,
  output logic [N-1:0] grant
);
  always_comb begin
    logic found;
    found = 1'b0;
    grant = '0;
    for (int i = 0; i < N; i++) begin
      if (!found && req[i] && elig[i]) begin
        grant[i] = 1'b1;
        found    = 1'b1;
      end
    end
  end
endmodule

// File: rtl/dispatch_sched.sv
module dispatch_sched
  import dsch_pkg::*;
#(
  parameter int N_CAP    = 2,
  parameter int ADDR_W   = 32,
  parameter int LEN_W    = 24,
  parameter int Q_DEPTH  = 8,
  parameter int PERIOD_W = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [PERIOD_W-1:0]     period_i,
  output logic                    cap_start_o,
  input  logic [N_CAP-1:0]        cap_rpt_valid_i,
  input  logic [N_CAP*ADDR_W-1:0] cap_rpt_addr_i,
  input  logic [N_CAP*LEN_W-1:0]  cap_rpt_len_i,
  output logic [N_CAP-1:0]        cap_rpt_ready_o,
  input  logic                    pdone_valid_i,
  input  logic [ADDR_W-1:0]       pdone_addr_i,
  input  logic [LEN_W-1:0]        pdone_len_i,
  output logic                    pdone_ready_o,
  input  logic                    nav_valid_i,
  input  logic [ADDR_W-1:0]       nav_addr_i,
  input  logic [LEN_W-1:0]        nav_len_i,
  output logic                    nav_ready_o,
  output logic                    proc_cmd_valid_o,
  output logic [ADDR_W-1:0]       proc_cmd_addr_o,
  output logic [LEN_W-1:0]        proc_cmd_len_o,
  input  logic                    proc_cmd_ready_i,
  output logic                    drv_cmd_valid_o,
  output logic [ADDR_W-1:0]       drv_cmd_addr_o,
  output logic [LEN_W-1:0]        drv_cmd_len_o,
  output logic [1:0]              drv_cmd_tag_o,
  input  logic                    drv_cmd_ready_i,
  output logic                    cop_cmd_valid_o,
  output logic [ADDR_W-1:0]       cop_cmd_addr_o,
  output logic [LEN_W-1:0]        cop_cmd_len_o,
  input  logic                    cop_cmd_ready_i
);
  localparam int NREQ    = N_CAP + 2;
  localparam int PD_IDX  = N_CAP;
  localparam int NAV_IDX = N_CAP + 1;
  localparam int PW      = ADDR_W + LEN_W;
  localparam int TW      = PW + 2;

  logic [NREQ-1:0] req, elig, grant;
  logic            proc_full, drv_full, cop_full;
  logic            proc_wr, drv_wr, cop_wr;
  logic [PW-1:0]   proc_wdata, proc_q, cop_q;
  logic [TW-1:0]   drv_wdata, drv_q;

  // start strobe
  dsch_timer #(.PERIOD_W(PERIOD_W)) u_timer (
    .clk(clk), .rst(rst), .period_i(period_i), .start_o(cap_start_o)
  );

  // requesters: capture units, then processing result, then navigation
  assign req = {nav_valid_i, pdone_valid_i, cap_rpt_valid_i};

  always_comb begin
    elig = '0;
    for (int i = 0; i < N_CAP; i++) elig[i] = !proc_full;
    elig[PD_IDX]  = !drv_full && !cop_full;
    elig[NAV_IDX] = !drv_full;
  end

  dsch_arb #(.N(NREQ)) u_arb (.req(req), .elig(elig), .grant(grant));

  assign cap_rpt_ready_o = grant[N_CAP-1:0];
  assign pdone_ready_o   = grant[PD_IDX];
  assign nav_ready_o     = grant[NAV_IDX];

  // routing
  always_comb begin
    proc_wdata = '0;
    for (int i = 0; i < N_CAP; i++) begin
      if (grant[i])
        proc_wdata = {cap_rpt_addr_i[i*ADDR_W +: ADDR_W], cap_rpt_len_i[i*LEN_W +: LEN_W]};
    end
  end

  assign proc_wr   = |grant[N_CAP-1:0];
  assign drv_wr    = grant[PD_IDX] | grant[NAV_IDX];
  assign cop_wr    = grant[PD_IDX];
  assign drv_wdata = grant[PD_IDX] ? {pdone_addr_i, pdone_len_i, TAG_PROC}
                                   : {nav_addr_i, nav_len_i, TAG_NAV};

  dsch_fifo #(.WIDTH(PW), .DEPTH(Q_DEPTH)) u_proc_q (
    .clk(clk), .rst(rst), .wr_en(proc_wr), .wr_data(proc_wdata),
    .full_o(proc_full), .out_valid(proc_cmd_valid_o), .out_data(proc_q),
    .out_ready(proc_cmd_ready_i)
  );

  dsch_fifo #(.WIDTH(TW), .DEPTH(Q_DEPTH)) u_drv_q (
    .clk(clk), .rst(rst), .wr_en(drv_wr), .wr_data(drv_wdata),
    .full_o(drv_full), .out_valid(drv_cmd_valid_o), .out_data(drv_q),
    .out_ready(drv_cmd_ready_i)
  );

  dsch_fifo #(.WIDTH(PW), .DEPTH(Q_DEPTH)) u_cop_q (
    .clk(clk), .rst(rst), .wr_en(cop_wr), .wr_data({pdone_addr_i, pdone_len_i}),
    .full_o(cop_full), .out_valid(cop_cmd_valid_o), .out_data(cop_q),
    .out_ready(cop_cmd_ready_i)
  );

  assign proc_cmd_addr_o = proc_q[PW-1 -: ADDR_W];
  assign proc_cmd_len_o  = proc_q[LEN_W-1:0];
  assign drv_cmd_addr_o  = drv_q[TW-1 -: ADDR_W];
  assign drv_cmd_len_o   = drv_q[TW-ADDR_W-1 -: LEN_W];
  assign drv_cmd_tag_o   = drv_q[1:0];
  assign cop_cmd_addr_o  = cop_q[PW-1 -: ADDR_W];
  assign cop_cmd_len_o   = cop_q[LEN_W-1:0];
endmodule

// File: rtl/dsch_checker.sv
module dsch_checker #(
  parameter int N_CAP    = 2,
  parameter int ADDR_W   = 32,
  parameter int LEN_W    = 24,
  parameter int Q_DEPTH  = 8,
  parameter int PERIOD_W = 16
) (
  input logic                clk,
  input logic                rst,
  input logic [PERIOD_W-1:0] period_i,
  input logic                cap_start_o,
  input logic [N_CAP-1:0]    cap_rpt_valid_i,
  input logic [N_CAP-1:0]    cap_rpt_ready_o,
  input logic                pdone_valid_i,
  input logic                pdone_ready_o,
  input logic                nav_valid_i,
  input logic                nav_ready_o,
  input logic                proc_cmd_valid_o,
  input logic [ADDR_W-1:0]   proc_cmd_addr_o,
  input logic [LEN_W-1:0]    proc_cmd_len_o,
  input logic                proc_cmd_ready_i,
  input logic                drv_cmd_valid_o,
  input logic [ADDR_W-1:0]   drv_cmd_addr_o,
  input logic [1:0]          drv_cmd_tag_o,
  input logic                drv_cmd_ready_i,
  input logic                cop_cmd_valid_o,
  input logic                cop_cmd_ready_i
);
  int proc_occ, drv_occ, cop_occ;
  logic proc_in, drv_in, cop_in;

  assign proc_in = |(cap_rpt_valid_i & cap_rpt_ready_o);
  assign drv_in  = (pdone_valid_i && pdone_ready_o) || (nav_valid_i && nav_ready_o);
  assign cop_in  = pdone_valid_i && pdone_ready_o;

  // occupancy rebuilt from channel traffic only
  always_ff @(posedge clk) begin
    if (rst) begin
      proc_occ <= 0;
      drv_occ  <= 0;
      cop_occ  <= 0;
    end else begin
      proc_occ <= proc_occ + int'(proc_in) - int'(proc_cmd_valid_o && proc_cmd_ready_i);
      drv_occ  <= drv_occ + int'(drv_in) - int'(drv_cmd_valid_o && drv_cmd_ready_i);
      cop_occ  <= cop_occ + int'(cop_in) - int'(cop_cmd_valid_o && cop_cmd_ready_i);
    end
  end

  a_r1_no_double_strobe: assert property (@(posedge clk) disable iff (rst)
    (cap_start_o && period_i > 1) |=> (!cap_start_o || period_i != $past(period_i)));

  a_r5_one_accept: assert property (@(posedge clk) disable iff (rst)
    $onehot0({nav_ready_o, pdone_ready_o, cap_rpt_ready_o}));

  a_r5_ready_needs_valid: assert property (@(posedge clk) disable iff (rst)
    ((cap_rpt_ready_o & ~cap_rpt_valid_i) == '0) && (!pdone_ready_o || pdone_valid_i)
    && (!nav_ready_o || nav_valid_i));

  for (genvar i = 1; i < N_CAP; i++) begin : g_prio
    a_r5_low_index_first: assert property (@(posedge clk) disable iff (rst)
      cap_rpt_valid_i[i-1] |-> !cap_rpt_ready_o[i]);
  end

  a_r5_nav_yields: assert property (@(posedge clk) disable iff (rst)
    (pdone_valid_i && drv_occ < Q_DEPTH && cop_occ < Q_DEPTH) |-> !nav_ready_o);

  a_r6_proc_bound: assert property (@(posedge clk) disable iff (rst)
    proc_occ <= Q_DEPTH && drv_occ <= Q_DEPTH && cop_occ <= Q_DEPTH);

  a_r6_proc_stall: assert property (@(posedge clk) disable iff (rst)
    (proc_occ == Q_DEPTH) |-> (cap_rpt_ready_o == '0));

  a_r6_nav_stall: assert property (@(posedge clk) disable iff (rst)
    (drv_occ == Q_DEPTH) |-> !nav_ready_o);

  a_r9_pdone_stall: assert property (@(posedge clk) disable iff (rst)
    (drv_occ == Q_DEPTH || cop_occ == Q_DEPTH) |-> !pdone_ready_o);

  a_r7_proc_hold: assert property (@(posedge clk) disable iff (rst)
    (proc_cmd_valid_o && !proc_cmd_ready_i) |=>
      (proc_cmd_valid_o && $stable(proc_cmd_addr_o) && $stable(proc_cmd_len_o)));

  a_r7_drv_hold: assert property (@(posedge clk) disable iff (rst)
    (drv_cmd_valid_o && !drv_cmd_ready_i) |=>
      (drv_cmd_valid_o && $stable(drv_cmd_addr_o) && $stable(drv_cmd_tag_o)));

  a_r3_drv_tag_legal: assert property (@(posedge clk) disable iff (rst)
    drv_cmd_valid_o |-> (drv_cmd_tag_o == 2'd1 || drv_cmd_tag_o == 2'd2));
endmodule

bind dispatch_sched dsch_checker #(
  .N_CAP(N_CAP), .ADDR_W(ADDR_W), .LEN_W(LEN_W), .Q_DEPTH(Q_DEPTH), .PERIOD_W(PERIOD_W)
) u_chk (
  .clk(clk), .rst(rst), .period_i(period_i), .cap_start_o(cap_start_o),
  .cap_rpt_valid_i(cap_rpt_valid_i), .cap_rpt_ready_o(cap_rpt_ready_o),
  .pdone_valid_i(pdone_valid_i), .pdone_ready_o(pdone_ready_o),
  .nav_valid_i(nav_valid_i), .nav_ready_o(nav_ready_o),
  .proc_cmd_valid_o(proc_cmd_valid_o), .proc_cmd_addr_o(proc_cmd_addr_o),
  .proc_cmd_len_o(proc_cmd_len_o), .proc_cmd_ready_i(proc_cmd_ready_i),
  .drv_cmd_valid_o(drv_cmd_valid_o), .drv_cmd_addr_o(drv_cmd_addr_o),
  .drv_cmd_tag_o(drv_cmd_tag_o), .drv_cmd_ready_i(drv_cmd_ready_i),
  .cop_cmd_valid_o(cop_cmd_valid_o), .cop_cmd_ready_i(cop_cmd_ready_i)
);

// File: tb/dispatch_sched_bench.sv
module dispatch_sched_bench;
  localparam int N_CAP = 2;
  localparam int AW = 32;
  localparam int LW = 24;
  localparam int QD = 8;
  localparam int PWD = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [PWD-1:0]      period;
  logic                start;
  logic [N_CAP-1:0]    cap_valid, cap_ready;
  logic [N_CAP*AW-1:0] cap_addr;
  logic [N_CAP*LW-1:0] cap_len;
  logic                pd_valid, pd_ready, nav_valid, nav_ready;
  logic [AW-1:0]       pd_addr, nav_addr;
  logic [LW-1:0]       pd_len, nav_len;
  logic                p_valid, p_ready, d_valid, d_ready, c_valid, c_ready;
  logic [AW-1:0]       p_addr, d_addr, c_addr;
  logic [LW-1:0]       p_len, d_len, c_len;
  logic [1:0]          d_tag;

  int n_chk = 0;
  int n_bad = 0;
  bit ok;

  always #10 clk = ~clk;

  dispatch_sched #(.N_CAP(N_CAP), .ADDR_W(AW), .LEN_W(LW), .Q_DEPTH(QD), .PERIOD_W(PWD))
  u_dispatch_sched (
    .clk(clk), .rst(rst), .period_i(period), .cap_start_o(start),
    .cap_rpt_valid_i(cap_valid), .cap_rpt_addr_i(cap_addr), .cap_rpt_len_i(cap_len),
    .cap_rpt_ready_o(cap_ready),
    .pdone_valid_i(pd_valid), .pdone_addr_i(pd_addr), .pdone_len_i(pd_len),
    .pdone_ready_o(pd_ready),
    .nav_valid_i(nav_valid), .nav_addr_i(nav_addr), .nav_len_i(nav_len),
    .nav_ready_o(nav_ready),
    .proc_cmd_valid_o(p_valid), .proc_cmd_addr_o(p_addr), .proc_cmd_len_o(p_len),
    .proc_cmd_ready_i(p_ready),
    .drv_cmd_valid_o(d_valid), .drv_cmd_addr_o(d_addr), .drv_cmd_len_o(d_len),
    .drv_cmd_tag_o(d_tag), .drv_cmd_ready_i(d_ready),
    .cop_cmd_valid_o(c_valid), .cop_cmd_addr_o(c_addr), .cop_cmd_len_o(c_len),
    .cop_cmd_ready_i(c_ready)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset(input int p);
    @(negedge clk);
    rst = 1'b1; period = PWD'(p);
    cap_valid = '0; cap_addr = '0; cap_len = '0;
    pd_valid = 0; pd_addr = '0; pd_len = '0;
    nav_valid = 0; nav_addr = '0; nav_len = '0;
    p_ready = 0; d_ready = 0; c_ready = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic push_cap(input int i, input logic [AW-1:0] a, input logic [LW-1:0] l, output bit acc);
    cap_valid[i] = 1'b1; cap_addr[i*AW +: AW] = a; cap_len[i*LW +: LW] = l;
    #1 acc = cap_ready[i];
    @(negedge clk); cap_valid[i] = 1'b0;
  endtask

  task automatic push_pd(input logic [AW-1:0] a, input logic [LW-1:0] l, output bit acc);
    pd_valid = 1'b1; pd_addr = a; pd_len = l;
    #1 acc = pd_ready;
    @(negedge clk); pd_valid = 1'b0;
  endtask

  task automatic push_nav(input logic [AW-1:0] a, input logic [LW-1:0] l, output bit acc);
    nav_valid = 1'b1; nav_addr = a; nav_len = l;
    #1 acc = nav_ready;
    @(negedge clk); nav_valid = 1'b0;
  endtask

  task automatic pop_proc(input logic [AW-1:0] a, input logic [LW-1:0] l, input string req);
    chk({req, " proc valid"}, 64'(p_valid), 64'd1);
    chk({req, " proc addr"}, 64'(p_addr), 64'(a));
    chk({req, " proc len"}, 64'(p_len), 64'(l));
    p_ready = 1'b1;
    @(negedge clk); p_ready = 1'b0;
  endtask

  task automatic pop_drv(input logic [AW-1:0] a, input logic [LW-1:0] l, input logic [1:0] t,
                         input string req);
    chk({req, " drv valid"}, 64'(d_valid), 64'd1);
    chk({req, " drv addr"}, 64'(d_addr), 64'(a));
    chk({req, " drv len"}, 64'(d_len), 64'(l));
    chk({req, " drv tag"}, 64'(d_tag), 64'(t));
    d_ready = 1'b1;
    @(negedge clk); d_ready = 1'b0;
  endtask

  task automatic pop_cop(input logic [AW-1:0] a, input logic [LW-1:0] l, input string req);
    chk({req, " cop valid"}, 64'(c_valid), 64'd1);
    chk({req, " cop addr"}, 64'(c_addr), 64'(a));
    chk({req, " cop len"}, 64'(c_len), 64'(l));
    c_ready = 1'b1;
    @(negedge clk); c_ready = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    // R8 reset state, R1 period zero
    do_reset(0);
    @(negedge clk);
    chk("R8 proc valid", 64'(p_valid), 0);
    chk("R8 drv valid", 64'(d_valid), 0);
    chk("R8 cop valid", 64'(c_valid), 0);
    chk("R8 start", 64'(start), 0);
    begin
      int seen = 0;
      for (int n = 0; n < 30; n++) begin @(negedge clk); seen += int'(start); end
      chk("R1 period zero strobes", 64'(seen), 0);
    end

    // R1 period sweep
    for (int p = 1; p <= 6; p++) begin
      do_reset(p);
      for (int n = 1; n <= 4 * p + 1; n++) begin
        @(negedge clk);
        chk($sformatf("R1 p=%0d edge=%0d", p, n), 64'(start), 64'((n % p) == 0));
      end
    end

    do_reset(0);
    // R7 latency from report to command
    push_cap(0, 32'h1000, 24'h40, ok);
    chk("R2 first report accepted", 64'(ok), 1);
    chk("R7 not yet valid", 64'(p_valid), 0);
    @(negedge clk);
    chk("R7 valid one edge later", 64'(p_valid), 1);
    pop_proc(32'h1000, 24'h40, "R2");

    // R2 and R6: fill processing queue
    for (int j = 0; j < QD; j++) begin
      push_cap(j % 2, 32'h2000 + 32'(j * 16), 24'(j + 1), ok);
      chk($sformatf("R6 fill %0d accepted", j), 64'(ok), 1);
    end
    push_cap(0, 32'h3000, 24'd5, ok);
    chk("R6 full rejects unit 0", 64'(ok), 0);
    push_cap(1, 32'h3010, 24'd5, ok);
    chk("R6 full rejects unit 1", 64'(ok), 0);
    // R5 ineligible capture does not block navigation
    cap_valid[0] = 1'b1; nav_valid = 1'b1; nav_addr = 32'h3300; nav_len = 24'd7;
    #1;
    chk("R5 full capture ready low", 64'(cap_ready[0]), 0);
    chk("R5 nav passes full capture", 64'(nav_ready), 1);
    @(negedge clk); cap_valid[0] = 1'b0; nav_valid = 1'b0;
    pop_proc(32'h2000, 24'd1, "R2");
    push_cap(1, 32'h3100, 24'd9, ok);
    chk("R6 accepted after space frees", 64'(ok), 1);
    for (int j = 1; j < QD; j++) pop_proc(32'h2000 + 32'(j * 16), 24'(j + 1), "R2");
    pop_proc(32'h3100, 24'd9, "R6");
    chk("R6 rejected reports left no entry", 64'(p_valid), 0);
    pop_drv(32'h3300, 24'd7, 2'd2, "R4");

    // R5 priority among capture units
    cap_valid = 2'b11;
    cap_addr = {32'h4100, 32'h4000}; cap_len = {24'd2, 24'd1};
    #1;
    chk("R5 unit 0 ready", 64'(cap_ready[0]), 1);
    chk("R5 unit 1 waits", 64'(cap_ready[1]), 0);
    @(negedge clk); cap_valid[0] = 1'b0;
    #1 chk("R5 unit 1 next", 64'(cap_ready[1]), 1);
    @(negedge clk); cap_valid[1] = 1'b0;
    pop_proc(32'h4000, 24'd1, "R5");
    pop_proc(32'h4100, 24'd2, "R5");

    // R5 result before navigation, R3/R4 routing
    pd_valid = 1; pd_addr = 32'h5000; pd_len = 24'd3;
    nav_valid = 1; nav_addr = 32'h5100; nav_len = 24'd4;
    #1;
    chk("R5 result ready", 64'(pd_ready), 1);
    chk("R5 nav waits", 64'(nav_ready), 0);
    @(negedge clk); pd_valid = 0;
    #1 chk("R5 nav next", 64'(nav_ready), 1);
    @(negedge clk); nav_valid = 0;
    @(negedge clk);
    pop_drv(32'h5000, 24'd3, 2'd1, "R3");
    pop_drv(32'h5100, 24'd4, 2'd2, "R4");
    pop_cop(32'h5000, 24'd3, "R3");
    chk("R4 nav absent from cop", 64'(c_valid), 0);

    // R5 capture beats navigation
    cap_valid[1] = 1; cap_addr[AW +: AW] = 32'h5200; cap_len[LW +: LW] = 24'd6;
    nav_valid = 1; nav_addr = 32'h5300; nav_len = 24'd8;
    #1;
    chk("R5 capture over nav", 64'(cap_ready[1]), 1);
    chk("R5 nav behind capture", 64'(nav_ready), 0);
    @(negedge clk); cap_valid[1] = 0;
    #1 chk("R5 nav after capture", 64'(nav_ready), 1);
    @(negedge clk); nav_valid = 0;
    @(negedge clk);
    pop_proc(32'h5200, 24'd6, "R5");
    pop_drv(32'h5300, 24'd8, 2'd2, "R4");

    // R7 hold while not ready
    push_nav(32'h6000, 24'd3, ok);
    @(negedge clk);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk("R7 held valid", 64'(d_valid), 1);
      chk("R7 held addr", 64'(d_addr), 64'h6000);
    end
    pop_drv(32'h6000, 24'd3, 2'd2, "R7");

    // R9: co-processor queue full, drive queue empty
    for (int j = 0; j < QD; j++) begin
      push_pd(32'h7000 + 32'(j * 4), 24'(j), ok);
      chk("R3 result accepted", 64'(ok), 1);
    end
    @(negedge clk);
    for (int j = 0; j < QD; j++) pop_drv(32'h7000 + 32'(j * 4), 24'(j), 2'd1, "R3");
    push_pd(32'h7F00, 24'd1, ok);
    chk("R9 result held when cop full", 64'(ok), 0);
    push_nav(32'h7E00, 24'd2, ok);
    chk("R9 nav still accepted", 64'(ok), 1);
    for (int j = 0; j < QD; j++) pop_cop(32'h7000 + 32'(j * 4), 24'(j), "R9");
    chk("R9 held result not in cop", 64'(c_valid), 0);
    pop_drv(32'h7E00, 24'd2, 2'd2, "R9");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule